// File: doc/BRIEF.md
# Multi-Rate TDM Serial Receiver

This block takes a set of serial time-division multiplexed input lines. All of them are timed from a single 32.768 MHz master clock. The lines are arranged in groups. Each group runs at one of five bit rates, from one master clock per bit up to sixteen master clocks per bit. Every line is sampled once per bit cell and its bits are assembled into 8-bit channels. Each completed channel is presented on a per-line data-memory write port, together with its channel number within the frame. The line index is the stream part of the memory address, since each line has its own write lane.

A frame pulse marks each 125 µs frame. The block works out the polarity of that pulse by itself from the first transition it sees after reset. A pulse that goes low selects the mode that samples on rising edges. A pulse that goes high selects the mode that samples half a clock later, on falling edges. Each line can also be given its own frame delay, in half-clock steps, so that lines reaching the block along different paths can still be aligned.

Top module: `tdm_rx_mrate`

## Requirements
- R1: After reset no `wr_en` bit is high, and none goes high before the first transition of `fp_in` after reset.
- R2: The first `fp_in` transition after reset fixes the polarity until the next reset. A fall to 0 selects an active-low pulse with rising-edge sampling. A rise to 1 selects an active-high pulse with sampling half a clock later. The frame starts at the clock edge that first samples the active level; transitions to the idle level are ignored.
- R3: `grp_rate[3g+2:3g]` sets the rate of group g, and line s belongs to group s / LANES_PER_GROUP. Code 0 gives 16 clocks per bit, 1 gives 8, 2 gives 4, 3 gives 2 and 4 gives 1. Codes 5 to 7 behave as code 4.
- R4: Bit n of a frame is sampled at master clock n*C + C/2 after the line's start, where C is the number of clocks per bit (C/2 is 0 when C is 1).
- R5: `strm_ofs[4s+3:4s]` delays the start of line s by that many half clocks (0 to 15). In the falling-edge mode this delay adds to the built-in half clock.
- R6: Bits are received most significant first. `wr_data` holds the eight bits of one channel in arrival order.
- R7: `wr_en[s]` is high for exactly one clock. That clock follows the edge that samples the eighth bit of a channel.
- R8: `wr_chan` counts channels from 0 at the line's delayed frame start. It runs up to FRAME_CLKS/(8*C) - 1 and then wraps with the frame.
- R9: A channel whose first bit would fall before the first delayed frame start after reset is never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (32.768 MHz in service) |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_in | input | 1 | Frame pulse, polarity detected automatically |
| rx_in | input | GROUPS*LANES_PER_GROUP | Serial input lines, bit s is line s |
| grp_rate | input | 3*GROUPS | Rate code per group |
| strm_ofs | input | 4*GROUPS*LANES_PER_GROUP | Half-clock start delay per line |
| wr_en | output | GROUPS*LANES_PER_GROUP | Per-line data-memory write strobe |
| wr_chan | output | CHW*GROUPS*LANES_PER_GROUP | Channel address per line, CHW = log2(FRAME_CLKS) - 3 |
| wr_data | output | 8*GROUPS*LANES_PER_GROUP | Received byte per line |

## Verification
Let k count clock edges from the edge that samples the active frame level (k = 0 there). Let W be half of (offset + polarity half-step), rounded down. Bit n of a line is then captured at edge k = n*C + C/2 + W + 1, and the write for a channel is visible during the clock after the edge that captures its bit 7. The bench rebuilds each line's waveform in half-clock units from these formulas. It drives the line a quarter period before each rising and falling edge, and compares all write lanes two nanoseconds after every rising edge against the edge index the formula predicts. No write is expected for any edge with k below 1.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int RATE_W = 3;
  localparam int OFS_W  = 4;
  localparam int BYTE_W = 8;

  // log2 of clocks per bit for a rate code; codes above 4 fold onto 4
  function automatic logic [2:0] rate_shift(input logic [RATE_W-1:0] code);
    return (code >= 3'd4) ? 3'd0 : 3'd4 - code;
  endfunction
endpackage

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture #(
  parameter int NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] rx_in,
  output logic [NS-1:0] smp_p,
  output logic [NS-1:0] smp_n
);
  // rising-edge copy of every line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_p <= '0;
    else        smp_p <= rx_in;
  end

  // falling-edge copy, used for odd half-clock sample points
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) smp_n <= '0;
    else        smp_n <= rx_in;
  end
endmodule

// File: rtl/tdm_rx_frame.sv
module tdm_rx_frame #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_in,
  output logic [TW-1:0] tick,
  output logic          locked,
  output logic          gci
);
  logic          fp_d, fp_v;
  logic          edge_s, start_s;
  logic          locked_d, gci_d;
  logic [TW-1:0] tick_d;

  always_comb begin
    edge_s   = fp_v && (fp_in != fp_d);
    // R2: before lock any transition starts a frame; afterwards only the active level
    start_s  = edge_s && (!locked || (fp_in == gci));
    locked_d = locked | edge_s;
    gci_d    = locked ? gci : (edge_s ? fp_in : gci);
    tick_d   = start_s ? '0 : tick + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fp_d   <= 1'b0;
      fp_v   <= 1'b0;
      locked <= 1'b0;
      gci    <= 1'b0;
      tick   <= '0;
    end else begin
      fp_d   <= fp_in;
      fp_v   <= 1'b1;
      locked <= locked_d;
      gci    <= gci_d;
      tick   <= tick_d;
    end
  end
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
  import tdm_rx_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     tick,
  input  logic              locked,
  input  logic              gci,
  input  logic [RATE_W-1:0] rate,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              smp_p,
  input  logic              smp_n,
  output logic              wr_en,
  output logic [TW-4:0]     wr_chan,
  output logic [BYTE_W-1:0] wr_data
);
  logic [4:0]        half_cnt;
  logic [3:0]        whole;
  logic [2:0]        sh;
  logic [TW-1:0]     pos, cell_len, bidx;
  logic              hit, last, bit_v;
  logic [BYTE_W-1:0] sh_q, sh_d, data_d;
  logic              go_q, go_d, wen_d;
  logic [TW-4:0]     chan_d;

  always_comb begin
    // R5: total delay in half clocks, falling-edge mode adds one half step
    half_cnt = {1'b0, ofs} + {4'b0, gci};
    whole    = half_cnt[4:1];
    pos      = tick - TW'(whole);
    sh       = rate_shift(rate);
    cell_len = TW'(1) << sh;
    hit      = (pos & (cell_len - TW'(1))) == (cell_len >> 1);
    bidx     = pos >> sh;
    bit_v    = half_cnt[0] ? smp_n : smp_p;
    last     = hit && (bidx[2:0] == 3'd7);
    sh_d     = hit ? {sh_q[BYTE_W-2:0], bit_v} : sh_q;
    go_d     = go_q | (locked && (pos == '0));
    wen_d    = go_q && last;
    data_d   = wen_d ? {sh_q[BYTE_W-2:0], bit_v} : wr_data;
    chan_d   = wen_d ? bidx[TW-1:3] : wr_chan;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      go_q    <= 1'b0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      wr_chan <= '0;
    end else begin
      sh_q    <= sh_d;
      go_q    <= go_d;
      wr_en   <= wen_d;
      wr_data <= data_d;
      wr_chan <= chan_d;
    end
  end
endmodule

// File: rtl/tdm_rx_mrate.sv
module tdm_rx_mrate
  import tdm_rx_pkg::*;
#(
  parameter int GROUPS          = 2,
  parameter int LANES_PER_GROUP = 2,
  parameter int FRAME_CLKS      = 4096,
  localparam int NS  = GROUPS * LANES_PER_GROUP,
  localparam int TW  = $clog2(FRAME_CLKS),
  localparam int CHW = TW - 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fp_in,
  input  logic [NS-1:0]        rx_in,
  input  logic [RATE_W*GROUPS-1:0] grp_rate,
  input  logic [OFS_W*NS-1:0]  strm_ofs,
  output logic [NS-1:0]        wr_en,
  output logic [CHW*NS-1:0]    wr_chan,
  output logic [BYTE_W*NS-1:0] wr_data
);
  logic [NS-1:0] smp_p, smp_n;
  logic [TW-1:0] tick;
  logic          locked, gci;

  tdm_rx_capture #(.NS(NS)) u_cap (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .smp_p(smp_p), .smp_n(smp_n)
  );

  tdm_rx_frame #(.TW(TW)) u_frm (
    .clk(clk), .rst_n(rst_n), .fp_in(fp_in),
    .tick(tick), .locked(locked), .gci(gci)
  );

  for (genvar s = 0; s < NS; s++) begin : g_lane
    tdm_rx_lane #(.TW(TW)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .locked  (locked),
      .gci     (gci),
      .rate    (grp_rate[(s / LANES_PER_GROUP)*RATE_W +: RATE_W]),
      .ofs     (strm_ofs[s*OFS_W +: OFS_W]),
      .smp_p   (smp_p[s]),
      .smp_n   (smp_n[s]),
      .wr_en   (wr_en[s]),
      .wr_chan (wr_chan[s*CHW +: CHW]),
      .wr_data (wr_data[s*BYTE_W +: BYTE_W])
    );
  end
endmodule

// File: rtl/tdm_rx_mrate_chk.sv
module tdm_rx_mrate_chk
  import tdm_rx_pkg::*;
#(
  parameter int GROUPS          = 2,
  parameter int LANES_PER_GROUP = 2,
  parameter int FRAME_CLKS      = 4096,
  localparam int NS  = GROUPS * LANES_PER_GROUP,
  localparam int CHW = $clog2(FRAME_CLKS) - 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NS-1:0]            wr_en,
  input logic [CHW*NS-1:0]        wr_chan,
  input logic [RATE_W*GROUPS-1:0] grp_rate,
  input logic                     locked,
  input logic                     gci
);
  a_r1_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (wr_en == '0));

  a_r2_polarity_held: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(gci)));

  for (genvar s = 0; s < NS; s++) begin : g_lane_chk
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[s] |=> !wr_en[s]);

    a_r8_chan_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[s] |-> (int'(wr_chan[s*CHW +: CHW]) <
        (FRAME_CLKS >> (3 + int'(rate_shift(grp_rate[(s / LANES_PER_GROUP)*RATE_W +: RATE_W]))))));
  end
endmodule

bind tdm_rx_mrate tdm_rx_mrate_chk #(
  .GROUPS(GROUPS), .LANES_PER_GROUP(LANES_PER_GROUP), .FRAME_CLKS(FRAME_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(wr_chan),
  .grp_rate(grp_rate), .locked(locked), .gci(gci)
);

// File: tb/tb_tdm_rx_mrate.sv
module tb_tdm_rx_mrate;
  localparam int GROUPS = 2;
  localparam int LPG    = 2;
  localparam int NS     = GROUPS * LPG;
  localparam int L      = 256;
  localparam int CHW    = 5;
  localparam int NFR    = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              fp_in;
  logic [NS-1:0]     rx_in;
  logic [3*GROUPS-1:0] grp_rate;
  logic [4*NS-1:0]   strm_ofs;
  logic [NS-1:0]     wr_en;
  logic [CHW*NS-1:0] wr_chan;
  logic [8*NS-1:0]   wr_data;

  always #10 clk = ~clk;

  tdm_rx_mrate #(.GROUPS(GROUPS), .LANES_PER_GROUP(LPG), .FRAME_CLKS(L)) dut (
    .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .rx_in(rx_in),
    .grp_rate(grp_rate), .strm_ofs(strm_ofs),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int f_abs = 0;
  int rate_v [GROUPS];
  int ofs_v  [NS];
  bit gci_v;
  string tag;

  function automatic logic [7:0] pat(int fr, int s, int ch);
    return 8'((fr * 37 + s * 71 + ch * 13 + 5) & 255);
  endfunction

  // R3: clocks per bit from rate code, codes above 4 fold onto 4
  function automatic int cpb_of(int s);
    int r = rate_v[s / LPG];
    return (r >= 4) ? 1 : (1 << (4 - r));
  endfunction

  // R5, R2: total start delay in half clocks
  function automatic int hd_of(int s);
    return ofs_v[s] + (gci_v ? 1 : 0);
  endfunction

  // level the line carries at half-clock instant hh (relative to the frame edge)
  function automatic logic line_bit(int s, int hh);
    int c = cpb_of(s);
    int m = c / 2;
    int x = hh - hd_of(s) - 2 * m + c;
    int n, cpf, nn;
    logic [7:0] b;
    if (x < 0) return 1'b0;
    n   = x / (2 * c);
    cpf = L / c;
    nn  = n % cpf;
    b   = pat(n / cpf, s, nn / 8);
    return b[7 - (nn % 8)];   // R6: MSB first
  endfunction

  task automatic chk(bit ok, string req, int s, int k, int got, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] lane %0d k=%0d got=%0d exp=%0d", req, tag, s, k, got, expv);
    end
  endtask

  // compare every lane against the edge index k
  task automatic check_edge(int k);
    for (int s = 0; s < NS; s++) begin
      int c = cpb_of(s);
      int m = c / 2;
      int w = hd_of(s) / 2;
      int q = k - 1 - m - w;
      bit e_en = 1'b0;
      int e_ch = 0;
      int e_dt = 0;
      if (k >= 1 && q >= 0 && (q % c) == 0 && ((q / c) % 8) == 7) begin
        int n   = q / c;
        int cpf = L / c;
        e_en = 1'b1;
        e_ch = (n % cpf) / 8;
        e_dt = pat(n / cpf, s, e_ch);
      end
      if (k < 1)
        chk(wr_en[s] == 1'b0, "R1", s, k, wr_en[s], 0);
      else
        chk(wr_en[s] == e_en, "R7 R9", s, k, wr_en[s], e_en);
      if (e_en && wr_en[s]) begin
        chk(int'(wr_chan[s*CHW +: CHW]) == e_ch, "R8", s, k, wr_chan[s*CHW +: CHW], e_ch);
        chk(int'(wr_data[s*8 +: 8]) == e_dt, "R4 R6", s, k, wr_data[s*8 +: 8], e_dt);
      end
    end
  endtask

  task automatic drive_lines(int hh);
    for (int s = 0; s < NS; s++) rx_in[s] = line_bit(s, hh);
  endtask

  task automatic run_phase(string t, int r0, int r1, int o0, int o1, int o2, int o3, bit g);
    tag = t;
    rate_v[0] = r0; rate_v[1] = r1;
    ofs_v[0] = o0; ofs_v[1] = o1; ofs_v[2] = o2; ofs_v[3] = o3;
    gci_v = g;
    grp_rate = {3'(r1), 3'(r0)};
    strm_ofs = {4'(o3), 4'(o2), 4'(o1), 4'(o0)};
    fp_in = g ? 1'b0 : 1'b1;
    rx_in = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    cyc += 3;
    #2;
    chk(wr_en == '0, "R1", 0, -1, wr_en, 0);   // reset state
    #3 rst_n = 1'b1;
    f_abs = cyc + 12;
    #10;
    for (int i = 0; i < NFR * L + 60; i++) begin
      int k = cyc + 1 - f_abs;
      bit act = (k >= 0) && (k % L == 0) && (k < NFR * L);
      fp_in = act ? gci_v : ~gci_v;   // R2: active level by polarity
      drive_lines(2 * k);
      @(posedge clk);
      cyc++;
      #2 check_edge(k);
      #3 drive_lines(2 * k + 1);
      #10;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    fp_in = 1'b1;
    rx_in = '0;
    grp_rate = '0;
    strm_ofs = '0;
    #15;
    // R2 R3 R4 R5: active-low pulse, 1 and 4 clocks per bit, odd and even delays
    run_phase("R2 R3 R5 stbus", 4, 2, 0, 3, 5, 0, 1'b0);
    // R2 R3 R5: active-high pulse, 16 and 2 clocks per bit, delay up to 15
    run_phase("R2 R3 R5 gci", 0, 3, 1, 0, 15, 8, 1'b1);
    // R3: folded rate code 6, 8 clocks per bit, large delays
    run_phase("R3 R5 fold", 6, 1, 15, 7, 0, 14, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired (R7 progress)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule